// File: doc/BRIEF.md
# Partial-Bypass Operand Forwarding Unit

This block sits in the operand-read stage of an in-order pipeline. The stages, in order, are fetch, decode, operand-read, execute-1, execute-2 and writeback. For each source operand of the instruction in operand-read, the block picks one of three outcomes. It takes the value from an in-flight producer over a forwarding path, it takes the register-file value, or it holds the instruction with a stall. The in-flight producers are presented as a list of producer slots. Slot 0 is the youngest, the one nearest operand-read. For every slot the block receives a write-enable, a result-ready bit, a destination tag and the result data.

The set of forwarding paths is fixed at build time by two masks. One mask has a bit per producer slot. The other has a bit per operand port. A path from slot s to port p exists only when both bits are set. Where a dependency cannot be served by an existing path, the block stalls until the producer reaches a slot that can deliver the value, or until it retires into the register file. The register file writes before it reads within a cycle, so writeback is not a producer slot.

The block also holds the operand-read to execute-1 register. On a stall that register takes a bubble, and operand-read stays frozen because the stall output goes upstream.

Top module: `fwd_unit`

## Requirements
- R1: A used source operand with a nonzero tag that no producer slot with its write-enable set is writing takes the value on its `rf_data` lane and causes no stall.
- R2: A used source operand with tag 0 reads as zero and never causes a stall, even when a producer slot writes tag 0.
- R3: When several slots write the tag of an operand, only the youngest one (the lowest slot index) decides the outcome. Older writers are ignored, even when the youngest cannot forward and an older one could.
- R4: A path from slot s to port p exists exactly when bit s of `SRC_FWD_MASK` and bit p of `DST_FWD_MASK` are both 1. If the deciding slot has its ready bit set and the path exists, the operand takes that slot's data with no stall. Example: slot 1 holds the product 10 for tag 1, and port 1 reads tag 3 from the register file with value 5. The operands are then 10 and 5 with no stall.
- R5: If the deciding slot is not ready, or its path to the port is absent, and `or_valid` is 1, then `stall` is 1. A stalled operand is never issued.
- R6: A producer moves down one slot per cycle. The stall lasts exactly the number of cycles until the producer sits in a slot that is ready and has a path to the port, or until it has left the last slot, whichever comes first.
- R7: In the cycle after a stall, `x1_valid` is 0. In the cycle after `or_valid` is 1 with no stall, `x1_valid` is 1 and `x1_opnd` lane p holds the operand chosen for port p.
- R8: An operand port with its `src_used` bit at 0 never causes a stall and passes its `rf_data` lane through.
- R9: While `rst_n` is low, `x1_valid` is 0 and `x1_opnd` is all zero.
- R10: While `or_valid` is 0, `stall` is 0, and in the next cycle `x1_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| or_valid | input | 1 | An instruction occupies operand-read |
| src_used | input | NPORT | Per-port operand-in-use bit |
| src_tag | input | NPORT*TAGW | Source register tag per port, port p in bits [p*TAGW +: TAGW] |
| rf_data | input | NPORT*XLEN | Register-file read value per port |
| prod_wen | input | NSRC | Slot s writes a register |
| prod_rdy | input | NSRC | Result of slot s is available |
| prod_tag | input | NSRC*TAGW | Destination tag per slot |
| prod_data | input | NSRC*XLEN | Result value per slot |
| stall | output | 1 | Hold fetch, decode and operand-read |
| x1_valid | output | 1 | Execute-1 holds an issued instruction |
| x1_opnd | output | NPORT*XLEN | Operands issued to execute-1 |

## Verification
On every cycle, the assertions check the local rules. Register 0 reads zero, unused ports are passed through, an operand that nobody writes comes from the register file, and a stall is followed by a bubble. Whether an absent path shows up as a stall instead of a wrong value, whether a present path avoids an unexpected stall, and how many cycles a stall lasts for each producer slot, ready point and port can only be shown by the bench's sweeps. Those sweeps run three mask configurations side by side and compare against arithmetic expectations.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    OPS_RF   = 2'd0,
    OPS_ZERO = 2'd1,
    OPS_FWD  = 2'd2,
    OPS_WAIT = 2'd3
  } opsrc_e;

  // Decide where one operand comes from, given the facts about its youngest writer.
  function automatic opsrc_e classify(input logic used, input logic zero_tag,
                                      input logic dep, input logic ready,
                                      input logic path);
    if (!used)          return OPS_RF;
    if (zero_tag)       return OPS_ZERO;
    if (!dep)           return OPS_RF;
    if (ready && path)  return OPS_FWD;
    return OPS_WAIT;
  endfunction

endpackage

// File: rtl/fwd_port_sel.sv
module fwd_port_sel
  import fwd_pkg::*;
#(
  parameter int              NSRC     = 7,
  parameter int              XLEN     = 32,
  parameter int              TAGW     = 5,
  parameter logic [NSRC-1:0] SRC_MASK = '1,
  parameter bit              DST_EN   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 src_used,
  input  logic [TAGW-1:0]      src_tag,
  input  logic [XLEN-1:0]      rf_val,
  input  logic [NSRC-1:0]      prod_wen,
  input  logic [NSRC-1:0]      prod_rdy,
  input  logic [NSRC*TAGW-1:0] prod_tag,
  input  logic [NSRC*XLEN-1:0] prod_data,
  output logic [XLEN-1:0]      opnd,
  output logic                 port_wait
);

  logic [NSRC-1:0] hit;
  logic [NSRC-1:0] yng;
  logic [XLEN-1:0] sel_data;
  logic            dep_live;
  logic            sel_rdy;
  logic            sel_path;
  logic            zero_tag;
  opsrc_e          kind;

  for (genvar gs = 0; gs < NSRC; gs++) begin : g_hit
    assign hit[gs] = prod_wen[gs] && (prod_tag[gs*TAGW +: TAGW] == src_tag);
  end

  // Lowest set bit = youngest writer.
  assign yng      = hit & (~hit + NSRC'(1));
  assign dep_live = |hit;
  assign zero_tag = (src_tag == '0);
  assign sel_rdy  = |(yng & prod_rdy);
  assign sel_path = DST_EN && (|(yng & SRC_MASK));

  always_comb begin
    sel_data = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (yng[s]) sel_data = sel_data | prod_data[s*XLEN +: XLEN];
    end
  end

  assign kind = classify(src_used, zero_tag, dep_live, sel_rdy, sel_path);

  always_comb begin
    unique case (kind)
      OPS_ZERO: opnd = '0;
      OPS_FWD:  opnd = sel_data;
      OPS_WAIT: opnd = sel_data;
      default:  opnd = rf_val;
    endcase
  end

  assign port_wait = (kind == OPS_WAIT);

  p_reg0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_used && src_tag == '0) |-> (!port_wait && opnd == '0));

  p_unused_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_used) |-> (!port_wait && opnd == rf_val));

  p_rf_when_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_used && src_tag != '0 && hit == '0) |-> (!port_wait && opnd == rf_val));

endmodule

// File: rtl/fwd_x1_reg.sv
module fwd_x1_reg #(
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [WIDTH-1:0] d,
  output logic             q_valid,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= issue;
      if (issue) q <= d;
    end
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int               NSRC         = 7,
  parameter int               NPORT        = 4,
  parameter int               XLEN         = 32,
  parameter int               TAGW         = 5,
  parameter logic [NSRC-1:0]  SRC_FWD_MASK = 7'b0000011,
  parameter logic [NPORT-1:0] DST_FWD_MASK = 4'b1111
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  or_valid,
  input  logic [NPORT-1:0]      src_used,
  input  logic [NPORT*TAGW-1:0] src_tag,
  input  logic [NPORT*XLEN-1:0] rf_data,
  input  logic [NSRC-1:0]       prod_wen,
  input  logic [NSRC-1:0]       prod_rdy,
  input  logic [NSRC*TAGW-1:0]  prod_tag,
  input  logic [NSRC*XLEN-1:0]  prod_data,
  output logic                  stall,
  output logic                  x1_valid,
  output logic [NPORT*XLEN-1:0] x1_opnd
);

  localparam int OPW = NPORT * XLEN;

  logic [NPORT-1:0] port_wait;
  logic [OPW-1:0]   sel_opnd;
  logic             wait_any;
  logic             issue;

  for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
    fwd_port_sel #(
      .NSRC     (NSRC),
      .XLEN     (XLEN),
      .TAGW     (TAGW),
      .SRC_MASK (SRC_FWD_MASK),
      .DST_EN   (DST_FWD_MASK[gp])
    ) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_used  (src_used[gp]),
      .src_tag   (src_tag[gp*TAGW +: TAGW]),
      .rf_val    (rf_data[gp*XLEN +: XLEN]),
      .prod_wen  (prod_wen),
      .prod_rdy  (prod_rdy),
      .prod_tag  (prod_tag),
      .prod_data (prod_data),
      .opnd      (sel_opnd[gp*XLEN +: XLEN]),
      .port_wait (port_wait[gp])
    );
  end

  assign wait_any = |port_wait;
  assign stall    = or_valid && wait_any;
  assign issue    = or_valid && !wait_any;

  fwd_x1_reg #(.WIDTH(OPW)) u_x1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .d       (sel_opnd),
    .q_valid (x1_valid),
    .q       (x1_opnd)
  );

  p_bubble_after_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !x1_valid);

  p_issue_after_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (or_valid && !stall) |=> x1_valid);

  p_idle_no_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!or_valid) |=> !x1_valid);

  p_no_writer_no_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_wen == '0) |-> !stall);

  p_unused_no_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_used == '0) |-> !stall);

endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;

  localparam int NS = 7;
  localparam int NP = 4;
  localparam int W  = 32;
  localparam int TW = 5;
  localparam int ND = 3;

  localparam logic [NS-1:0] SM0 = 7'b1010011;
  localparam logic [NP-1:0] DM0 = 4'b0101;
  localparam logic [NS-1:0] SM1 = 7'b0000000;
  localparam logic [NP-1:0] DM1 = 4'b1111;
  localparam logic [NS-1:0] SM2 = 7'b1111111;
  localparam logic [NP-1:0] DM2 = 4'b1111;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          or_valid;
  logic [NP-1:0] used;
  logic [TW-1:0] stag [NP];
  logic [W-1:0]  rfv  [NP];
  logic [NS-1:0] wen, rdy;
  logic [TW-1:0] ptag [NS];
  logic [W-1:0]  pdat [NS];

  logic [NP*TW-1:0] stag_f;
  logic [NP*W-1:0]  rfv_f;
  logic [NS*TW-1:0] ptag_f;
  logic [NS*W-1:0]  pdat_f;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      stag_f[p*TW +: TW] = stag[p];
      rfv_f[p*W +: W]    = rfv[p];
    end
    for (int s = 0; s < NS; s++) begin
      ptag_f[s*TW +: TW] = ptag[s];
      pdat_f[s*W +: W]   = pdat[s];
    end
  end

  logic           st [ND];
  logic           xv [ND];
  logic [NP*W-1:0] xo [ND];
  logic           last_st [ND];

  fwd_unit #(.NSRC(NS), .NPORT(NP), .XLEN(W), .TAGW(TW),
             .SRC_FWD_MASK(SM0), .DST_FWD_MASK(DM0)) u_dut (
    .clk(clk), .rst_n(rst_n), .or_valid(or_valid), .src_used(used),
    .src_tag(stag_f), .rf_data(rfv_f), .prod_wen(wen), .prod_rdy(rdy),
    .prod_tag(ptag_f), .prod_data(pdat_f),
    .stall(st[0]), .x1_valid(xv[0]), .x1_opnd(xo[0]));

  fwd_unit #(.NSRC(NS), .NPORT(NP), .XLEN(W), .TAGW(TW),
             .SRC_FWD_MASK(SM1), .DST_FWD_MASK(DM1)) u_none (
    .clk(clk), .rst_n(rst_n), .or_valid(or_valid), .src_used(used),
    .src_tag(stag_f), .rf_data(rfv_f), .prod_wen(wen), .prod_rdy(rdy),
    .prod_tag(ptag_f), .prod_data(pdat_f),
    .stall(st[1]), .x1_valid(xv[1]), .x1_opnd(xo[1]));

  fwd_unit #(.NSRC(NS), .NPORT(NP), .XLEN(W), .TAGW(TW),
             .SRC_FWD_MASK(SM2), .DST_FWD_MASK(DM2)) u_all (
    .clk(clk), .rst_n(rst_n), .or_valid(or_valid), .src_used(used),
    .src_tag(stag_f), .rf_data(rfv_f), .prod_wen(wen), .prod_rdy(rdy),
    .prod_tag(ptag_f), .prod_data(pdat_f),
    .stall(st[2]), .x1_valid(xv[2]), .x1_opnd(xo[2]));

  int errs   = 0;
  int checks = 0;

  function automatic logic [NS-1:0] smask(input int d);
    return (d == 0) ? SM0 : (d == 1) ? SM1 : SM2;
  endfunction

  function automatic logic [NP-1:0] dmask(input int d);
    return (d == 0) ? DM0 : (d == 1) ? DM1 : DM2;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected outcome of one port for configuration d.
  task automatic model(input int d, input int p, output logic s, output logic [W-1:0] v);
    int found;
    s = 1'b0;
    v = rfv[p];
    found = -1;
    if (used[p] && stag[p] != '0) begin
      for (int k = NS - 1; k >= 0; k--)
        if (wen[k] && ptag[k] == stag[p]) found = k;
      if (found >= 0) begin
        if (rdy[found] && smask(d)[found] && dmask(d)[p]) v = pdat[found];
        else s = 1'b1;
      end
    end else if (used[p]) begin
      v = '0;
    end
  endtask

  task automatic step_check(input string req);
    logic           es [ND];
    logic           ei [ND];
    logic [W-1:0]   ev [ND][NP];
    logic           any;
    logic           s;
    logic [W-1:0]   v;
    #1;
    for (int d = 0; d < ND; d++) begin
      any = 1'b0;
      for (int p = 0; p < NP; p++) begin
        model(d, p, s, v);
        ev[d][p] = v;
        any = any | s;
      end
      es[d] = or_valid && any;
      ei[d] = or_valid && !any;
      last_st[d] = st[d];
      chk(st[d] === es[d], req, $sformatf("stall cfg%0d", d), W'(st[d]), W'(es[d]));
    end
    @(posedge clk);
    #1;
    for (int d = 0; d < ND; d++) begin
      chk(xv[d] === ei[d], req, $sformatf("x1_valid cfg%0d", d), W'(xv[d]), W'(ei[d]));
      if (ei[d])
        for (int p = 0; p < NP; p++)
          chk(xo[d][p*W +: W] === ev[d][p], req, $sformatf("operand cfg%0d port%0d", d, p),
              xo[d][p*W +: W], ev[d][p]);
    end
  endtask

  task automatic clear_inputs();
    or_valid = 1'b0;
    used = '0;
    wen = '0;
    rdy = '0;
    for (int p = 0; p < NP; p++) begin
      stag[p] = '0;
      rfv[p]  = '0;
    end
    for (int s = 0; s < NS; s++) begin
      ptag[s] = '0;
      pdat[s] = '0;
    end
  endtask

  task automatic base_op();
    or_valid = 1'b1;
    used = '1;
    for (int p = 0; p < NP; p++) begin
      stag[p] = TW'(20 + p);
      rfv[p]  = 32'h100 + p;
    end
  endtask

  function automatic int exp_count(input int d, input int k, input int r, input int p);
    for (int j = 0; j <= NS; j++) begin
      if (k + j >= NS) return j;
      if (k + j >= r && smask(d)[k+j] && dmask(d)[p]) return j;
    end
    return NS + 1;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #2_000_000;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int cnt  [ND];
    bit done [ND];
    rst_n = 1'b0;
    clear_inputs();
    repeat (2) @(posedge clk);
    #1;
    for (int d = 0; d < ND; d++) begin
      chk(xv[d] === 1'b0, "R9", "reset x1_valid", W'(xv[d]), '0);
      chk(xo[d] === '0, "R9", "reset x1_opnd", xo[d][W-1:0], '0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: nobody writes the sources
    @(negedge clk); clear_inputs(); base_op();
    step_check("R1");
    chk(xo[1][3*W +: W] === 32'h103, "R1", "rf operand port3", xo[1][3*W +: W], 32'h103);

    // R2: tag 0 with a pending, unready writer of tag 0
    @(negedge clk); clear_inputs(); base_op();
    stag[2] = '0; wen[0] = 1'b1; ptag[0] = '0; pdat[0] = 32'hBAD;
    step_check("R2");
    chk(xo[1][2*W +: W] === '0, "R2", "zero operand", xo[1][2*W +: W], '0);

    // R4: product 10 in slot 1 for tag 1 on port 0, port 1 reads tag 3 = 5
    @(negedge clk); clear_inputs(); base_op();
    stag[0] = 5'd1; stag[1] = 5'd3; rfv[0] = 32'hDEAD; rfv[1] = 32'd5;
    wen[1] = 1'b1; rdy[1] = 1'b1; ptag[1] = 5'd1; pdat[1] = 32'd10;
    step_check("R4");
    chk(xo[0][0 +: W] === 32'd10, "R4", "forwarded product", xo[0][0 +: W], 32'd10);
    chk(xo[0][W +: W] === 32'd5, "R4", "rf operand", xo[0][W +: W], 32'd5);

    // R3: youngest wins
    @(negedge clk); clear_inputs(); base_op();
    stag[0] = 5'd7;
    wen[0] = 1'b1; rdy[0] = 1'b1; ptag[0] = 5'd7; pdat[0] = 32'hAAAA;
    wen[3] = 1'b1; rdy[3] = 1'b1; ptag[3] = 5'd7; pdat[3] = 32'hBBBB;
    step_check("R3");
    chk(xo[2][0 +: W] === 32'hAAAA, "R3", "youngest data", xo[2][0 +: W], 32'hAAAA);

    // R3: youngest has no path, older could forward: stall in cfg0
    @(negedge clk); clear_inputs(); base_op();
    stag[0] = 5'd7;
    wen[2] = 1'b1; rdy[2] = 1'b1; ptag[2] = 5'd7; pdat[2] = 32'hCCCC;
    wen[4] = 1'b1; rdy[4] = 1'b1; ptag[4] = 5'd7; pdat[4] = 32'hDDDD;
    step_check("R3");
    chk(last_st[0] === 1'b1, "R3", "no fall-through stall", W'(last_st[0]), 32'd1);

    // R7: unready producer then ready
    @(negedge clk); clear_inputs(); base_op();
    stag[1] = 5'd9; wen[0] = 1'b1; ptag[0] = 5'd9; pdat[0] = 32'hBAD;
    step_check("R7");
    chk(xv[2] === 1'b0, "R7", "bubble", W'(xv[2]), '0);
    @(negedge clk); rdy[0] = 1'b1; pdat[0] = 32'h5151;
    step_check("R7");
    chk(xo[2][W +: W] === 32'h5151, "R7", "issued after ready", xo[2][W +: W], 32'h5151);

    // R8: unused port with a pending writer of its tag
    @(negedge clk); clear_inputs(); base_op();
    used[3] = 1'b0; stag[3] = 5'd9; rfv[3] = 32'h3333;
    wen[0] = 1'b1; ptag[0] = 5'd9;
    step_check("R8");
    chk(xo[1][3*W +: W] === 32'h3333, "R8", "unused passthrough", xo[1][3*W +: W], 32'h3333);

    // R10: nothing in operand-read
    @(negedge clk); clear_inputs(); base_op();
    or_valid = 1'b0; stag[0] = 5'd9; wen[0] = 1'b1; ptag[0] = 5'd9;
    step_check("R10");
    chk(last_st[1] === 1'b0, "R10", "idle stall", W'(last_st[1]), '0);

    // R5 / R6: sweep slot, ready point and port
    for (int k = 0; k < NS; k++) begin
      for (int rr = 0; rr < 3; rr++) begin
        for (int p = 0; p < NP; p++) begin
          for (int d = 0; d < ND; d++) begin cnt[d] = 0; done[d] = 1'b0; end
          for (int j = 0; j <= NS - k; j++) begin
            @(negedge clk); clear_inputs(); base_op();
            stag[p] = 5'd7;
            if (k + j < NS) begin
              wen[k+j]  = 1'b1;
              ptag[k+j] = 5'd7;
              rdy[k+j]  = (k + j >= k + rr);
              pdat[k+j] = rdy[k+j] ? (32'h1000 + k*16 + rr) : 32'hBAD0;
              rfv[p]    = 32'hDEAD0000;
            end else begin
              rfv[p]    = 32'h1000 + k*16 + rr;
            end
            step_check("R5");
            for (int d = 0; d < ND; d++) begin
              if (!done[d]) begin
                if (last_st[d]) cnt[d]++;
                else done[d] = 1'b1;
              end
            end
          end
          for (int d = 0; d < ND; d++)
            chk(cnt[d] == exp_count(d, k, k + rr, p), "R6",
                $sformatf("stall cycles cfg%0d slot%0d ready%0d port%0d", d, k, k + rr, p),
                W'(cnt[d]), W'(exp_count(d, k, k + rr, p)));
        end
      end
    end

    summary();
    $finish;
  end

endmodule